// File: doc/BRIEF.md
# Bridge Interrupt Pending and Enable Controller

This block collects the interrupt and error sources of a host-side PCI bridge into one 32-bit word. The word can be read and written over a simple register port. It drives one shared interrupt line towards the system interrupt controller. Four level-sensitive INTx lines and six single-cycle error strobes feed the low half of the word. The enable for each source sits sixteen bits above its flag. A source requests an interrupt only when both its flag and its enable are set.

Software writes the word to change the enables and to acknowledge error flags. Writing an all-zero word turns every source off and drops every error flag, which gives firmware a one-write shutdown. The error strobes map onto flag bits 4 to 9 in this order:

- data parity detected
- target abort signalled
- target abort received
- master abort received
- system error signalled
- parity error detected

The block also answers a combinational routing query. Given a device slot number and its interrupt pin (1 to 4), it returns which bridge INTx input that pin arrives on after the usual slot rotation.

Top module: `bridge_irq_ctrl`

## Requirements
- R1: The read word is laid out as follows: bits 3:0 are the INTx flags (bit 0 is A), bits 9:4 are the error flags, and bits 25:16 are the enables, with each enable 16 bits above its flag. Bits 15:10 and 31:26 always read zero, and writes to them have no effect.
- R2: After reset, all flags are zero and the enables are 0x0E0 (both abort-received sources and target abort signalled), so the read word is 0x00E00000. The parameter ALL_ERRS=1 instead resets the enables to 0x3F0, which covers all six error sources.
- R3: Each INTx flag equals its input line as sampled at the previous clock edge. Register writes never change INTx flags, including writes of one to them while the line is held high.
- R4: Strobe bit k of `err_evt_i` sets error flag bit 4+k at the next edge. An error flag stays set while no write clears it.
- R5: A register write with a nonzero word clears each error flag whose bit in the written data is one, and leaves every other error flag unchanged.
- R6: When a strobe and a clearing write hit the same error flag in the same cycle, the flag ends up set.
- R7: A write of the all-zero word clears all six error flags (subject to R6) and all ten enables.
- R8: Every register write loads enable bits 25:16 from the write data.
- R9: `irq_o` is high exactly when some flag and its matching enable are both one. It follows the register contents with no further delay.
- R10: For `pin_i` in 1..4, `route_valid_o` is 1 and `route_o` = ((pin_i-1) + slot_i[1:0]) mod 4. For any other pin value, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| intx_i | input | 4 | Level INTx lines, bit 0 = A |
| err_evt_i | input | 6 | One-cycle error event strobes |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| irq_o | output | 1 | Shared interrupt request |
| slot_i | input | 5 | Device slot number for routing |
| pin_i | input | 3 | Device interrupt pin, 1..4 = A..D |
| route_o | output | 2 | Bridge INTx index the pin arrives on |
| route_valid_o | output | 1 | Pin value is in 1..4 |

## Verification
Directed sequences come first and isolate single effects:

- a lone strobe followed by idle cycles, which separates sticky from self-clearing flags;
- a one-to-clear write aimed at a single flag, which separates bitwise clearing from wholesale clearing;
- a strobe coinciding with its clear, which exposes the set/clear priority;
- an all-ones write, which exercises the reserved bits;
- an all-zero write, which separates the shutdown word from an ordinary write.

Held INTx lines combined with one-to-clear writes tell level tracking apart from latching. Several thousand random cycles then mix sparse strobes, random line levels and writes, including occasional zero words. Across these cycles the irq output is compared against the modelled enable-and-flag product. The routing function is swept over every slot and pin pair, which includes the invalid pin codes.

// File: rtl/bridge_irq_ctrl.sv
module bridge_irq_ctrl #(
  parameter int  N_INTX   = 4,
  parameter int  N_ERR    = 6,
  parameter int  EN_OFS   = 16,
  parameter int  SLOT_W   = 5,
  parameter bit  ALL_ERRS = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_INTX-1:0]     intx_i,
  input  logic [N_ERR-1:0]      err_evt_i,
  input  logic                  bus_wr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  irq_o,
  input  logic [SLOT_W-1:0]     slot_i,
  input  logic [2:0]            pin_i,
  output logic [1:0]            route_o,
  output logic                  route_valid_o
);
  localparam int NSRC = N_INTX + N_ERR;
  localparam logic [N_ERR-1:0] DEF_ERR_EN = N_ERR'(6'b001110);
  localparam logic [N_ERR-1:0] EXT_ERR_EN = '1;
  localparam logic [NSRC-1:0]  RST_EN =
    {(ALL_ERRS ? EXT_ERR_EN : DEF_ERR_EN), {N_INTX{1'b0}}};

  logic [N_INTX-1:0] intx_q;
  logic [N_ERR-1:0]  err_q;
  logic [NSRC-1:0]   en_q;
  logic [N_ERR-1:0]  clr;
  logic [NSRC-1:0]   flags;

  assign clr   = !bus_wr ? '0 :
                 (bus_wdata == 32'd0) ? '1 : bus_wdata[N_INTX +: N_ERR];
  assign flags = {err_q, intx_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intx_q <= '0;
      err_q  <= '0;
      en_q   <= RST_EN;
    end else begin
      intx_q <= intx_i;
      err_q  <= (err_q & ~clr) | err_evt_i;
      if (bus_wr) en_q <= bus_wdata[EN_OFS +: NSRC];
    end
  end

  always_comb begin
    bus_rdata = '0;
    bus_rdata[NSRC-1:0] = flags;
    bus_rdata[EN_OFS +: NSRC] = en_q;
  end

  assign irq_o = |(en_q & flags);

  logic [2:0] pin_m1;
  assign pin_m1        = pin_i - 3'd1;
  assign route_valid_o = (pin_i >= 3'd1) && (pin_i <= 3'd4);
  assign route_o       = route_valid_o ? (pin_m1[1:0] + slot_i[1:0]) : 2'd0;
endmodule

module bridge_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  intx_i,
  input logic [5:0]  err_evt_i,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        irq_o,
  input logic [2:0]  pin_i,
  input logic [1:0]  route_o,
  input logic        route_valid_o
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[15:10] == 6'd0) && (bus_rdata[31:26] == 6'd0));
  // R3
  intx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bus_rdata[3:0] == $past(intx_i));
  // R6
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt_i != 6'd0) |=> ((bus_rdata[9:4] & $past(err_evt_i)) == $past(err_evt_i)));
  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && err_evt_i == 6'd0) |=> $stable(bus_rdata[9:4]));
  // R8
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> bus_rdata[25:16] == $past(bus_wdata[25:16]));
  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((bus_rdata[25:16] & bus_rdata[9:0]) != 10'd0));
  // R10
  route_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !route_valid_o |-> (route_o == 2'd0 && (pin_i == 3'd0 || pin_i > 3'd4)));
endmodule

bind bridge_irq_ctrl bridge_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .intx_i(intx_i), .err_evt_i(err_evt_i),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_o(irq_o), .pin_i(pin_i), .route_o(route_o),
  .route_valid_o(route_valid_o)
);

// File: tb/test_bridge_irq_ctrl.sv
module test_bridge_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  intx_i = '0;
  logic [5:0]  err_evt_i = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic [4:0]  slot_i = '0;
  logic [2:0]  pin_i = '0;
  logic [1:0]  route_o;
  logic        route_valid_o;

  int n_run = 0;
  int n_fail = 0;
  logic [3:0] m_intx;
  logic [5:0] m_err;
  logic [9:0] m_en;

  always #5 clk = ~clk;

  bridge_irq_ctrl i_bridge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .intx_i(intx_i), .err_evt_i(err_evt_i),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .slot_i(slot_i), .pin_i(pin_i), .route_o(route_o),
    .route_valid_o(route_valid_o)
  );

  function automatic logic [31:0] pack_word(logic [3:0] ix, logic [5:0] er, logic [9:0] en);
    return {6'd0, en, 6'd0, er, ix};
  endfunction

  function automatic logic [2:0] exp_route(logic [4:0] s, logic [2:0] p);
    logic [1:0] r;
    if (p < 3'd1 || p > 3'd4) return 3'b000;
    r = 2'(p - 3'd1) + s[1:0];
    return {1'b1, r};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(logic [3:0] ix, logic [5:0] ev, logic wr, logic [31:0] wd,
                       string etag);
    logic [5:0] clr;
    intx_i = ix; err_evt_i = ev; bus_wr = wr; bus_wdata = wd;
    clr = !wr ? 6'd0 : (wd == 32'd0) ? 6'h3F : wd[9:4];
    m_err  = (m_err & ~clr) | ev;
    m_intx = ix;
    if (wr) m_en = wd[25:16];
    @(posedge clk); #2;
    check("R3 intx flags", {28'd0, bus_rdata[3:0]}, {28'd0, m_intx});
    check(etag, {26'd0, bus_rdata[9:4]}, {26'd0, m_err});
    check("R8 enables", {22'd0, bus_rdata[25:16]}, {22'd0, m_en});
    check("R1 reserved", {bus_rdata[31:26], bus_rdata[15:10]}, 32'd0);
    check("R9 irq", {31'd0, irq_o}, {31'd0, |(m_en & {m_err, m_intx})});
    @(negedge clk);
    err_evt_i = '0; bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R2 reset word", bus_rdata, 32'h00E0_0000);
    check("R2 reset irq", {31'd0, irq_o}, 32'd0);
    m_intx = '0; m_err = '0; m_en = 10'h0E0;

    cycle(4'h0, 6'b000010, 1'b0, 32'd0, "R4 strobe sets flag");
    check("R9 irq on enabled error", {31'd0, irq_o}, 32'd1);
    cycle(4'h0, 6'd0, 1'b0, 32'd0, "R4 flag sticky");
    cycle(4'h0, 6'b000100, 1'b0, 32'd0, "R4 second flag");
    cycle(4'h0, 6'd0, 1'b1, 32'h00E0_0020, "R5 selective clear");
    check("R5 other flag kept", {31'd0, bus_rdata[6]}, 32'd1);
    cycle(4'h0, 6'b000100, 1'b1, 32'h00E0_0040, "R6 set wins");
    check("R6 flag still set", {31'd0, bus_rdata[6]}, 32'd1);
    cycle(4'b1010, 6'd0, 1'b1, 32'hFFFF_FFFF, "R1 all ones write");
    check("R1 word after all ones", bus_rdata, 32'h03FF_000A);
    cycle(4'b1010, 6'd0, 1'b1, 32'h03FF_000F, "R3 w1c on intx");
    check("R3 intx held", {28'd0, bus_rdata[3:0]}, 32'hA);
    cycle(4'b1010, 6'b111111, 1'b0, 32'd0, "R4 all strobes");
    cycle(4'b0000, 6'd0, 1'b1, 32'd0, "R7 zero write");
    check("R7 word after zero", bus_rdata, 32'd0);
    check("R7 irq off", {31'd0, irq_o}, 32'd0);
    cycle(4'b0100, 6'b100000, 1'b1, 32'd0, "R6 zero write with strobe");
    check("R9 disabled sources no irq", {31'd0, irq_o}, 32'd0);
    cycle(4'b0100, 6'd0, 1'b1, 32'h0004_0000, "R8 enable intc");
    check("R9 irq from intx", {31'd0, irq_o}, 32'd1);

    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 3000; i++) begin
      logic [3:0]  ix;
      logic [5:0]  ev;
      logic        wr;
      logic [31:0] wd;
      ix = 4'($urandom);
      ev = ($urandom % 4 == 0) ? 6'($urandom) : 6'd0;
      wr = ($urandom % 5 == 0);
      wd = ($urandom % 8 == 0) ? 32'd0 : $urandom;
      cycle(ix, ev, wr, wd, "R5 random error flags");
    end

    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 8; p++) begin
        logic [2:0] e;
        slot_i = 5'(s); pin_i = 3'(p);
        #1;
        e = exp_route(5'(s), 3'(p));
        check("R10 route", {29'd0, route_valid_o, route_o}, {29'd0, e});
      end
    end
    @(negedge clk);
    finish_run();
  end
endmodule